// File: doc/BRIEF.md
# Pipeline Stage Activity and Energy Monitor

This block sits beside a six-stage in-order, fine-grained multi-threaded core. It watches the instruction-ready signal that each stage receives from the stage before it. It also watches a per-stage hold flag for an instruction that is parked waiting on memory or on a long-latency unit, and the load-miss flag raised by the memory stage. From these inputs it decides, every cycle, whether each stage is active or idle. That same decision drives the stage's clock-gate enable and its busy flag, so the power accounting is tied directly to the gating.

A six-entry table holds a fixed-point per-cycle leakage energy and dynamic energy for each stage. On every clock edge, each stage's saturating accumulator adds its leakage. An active stage also adds its dynamic energy. A core total, formed from the stage accumulators, is updated on the same edge. The block also counts elapsed cycles, retired instructions per hardware thread and retired instructions per core, so that software can form CPI as cycles divided by retirements over one window. A one-cycle clear pulse opens a new window.

The table is loaded over a valid/ready write port. Ready is held high, so a beat is taken in every cycle in which valid is high, and there is never back-pressure. Stage indices and bit positions are: 0 fetch, 1 thread select, 2 decode/branch, 3 execute, 4 memory access, 5 write-back.

Top module: `pem_top`

## Requirements
- R1: After reset, all stage energies, the core energy, the cycle count and all retirement counts read zero, and every table entry is zero.
- R2: Stage s is active, with gate_en[s] and stage_busy[s] both high in the same cycle (combinationally), whenever stage_rdy[s] is high.
- R3: A stage whose stage_hold[s] is high counts as active even when stage_rdy[s] is low; with both low the stage is idle and its gate enable is low.
- R4: On each clock edge where clear is low, stage s's energy grows by its leakage value, plus its dynamic value if the stage was active in that cycle.
- R5: When dcache_miss is high in a cycle, the write-back stage (bit 5) is idle in the following cycle, whatever its ready and hold inputs are.
- R6: cfg_ready is always high. A beat with cfg_idx below 6 replaces that entry's leakage and dynamic values. The new values are first used by the accumulation on the edge after the write edge. A beat with cfg_idx of 6 or 7 changes nothing.
- R7: A stage accumulator never wraps. It stops at all ones.
- R8: core_energy equals the sum of the six stage energies, saturated at all ones, and changes on the same edge as they do.
- R9: On each edge with retire_valid high and clear low, the counter of thread retire_tid and the core retirement count each rise by one.
- R10: cycle_count rises by one on every edge where clear is low, so CPI over a window is cycle_count divided by core_retired.
- R11: A clear pulse zeroes every energy, the cycle count and all retirement counts on that edge and wins over a simultaneous retirement. The table keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Window clear pulse |
| stage_rdy | input | 6 | Instruction-ready arriving at each stage |
| stage_hold | input | 6 | Stage holds a stalled instruction |
| dcache_miss | input | 1 | Load miss detected in the memory stage |
| cfg_valid | input | 1 | Table write beat valid |
| cfg_ready | output | 1 | Table write beat accepted (always high) |
| cfg_idx | input | 3 | Table entry index |
| cfg_leak | input | 16 | Leakage energy per cycle |
| cfg_dyn | input | 16 | Dynamic energy per active cycle |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_tid | input | 2 | Thread of the retiring instruction |
| gate_en | output | 6 | Clock-gate enable per stage |
| stage_busy | output | 6 | Active flag per stage |
| stage_energy | output | 288 | Six 48-bit stage energies, stage s at bits s*48 and up |
| core_energy | output | 48 | Saturated sum of stage energies |
| cycle_count | output | 32 | Cycles since clear or reset |
| thread_retired | output | 128 | Four 32-bit per-thread retirement counts |
| core_retired | output | 32 | Core retirement count |

## Verification
The activity logic is driven with a table of ready, hold and miss patterns. The patterns separate ready-only activity from hold-only activity, and they show that a miss idles write-back only in the cycle after it, even when that stage is ready or holding. Energy is then compared against an independent per-cycle model across mixed activity, so leakage-only cycles can be told apart from dynamic cycles. Directed cases follow:
- a table write, which shows the one-cycle delay before new values are used;
- an out-of-range index, which must change nothing;
- a second instance with narrow accumulators, which must pin at all ones instead of wrapping;
- interleaved retirements across threads;
- a clear that coincides with a retirement.

// File: rtl/pem_pkg.sv
package pem_pkg;
  localparam int PWR_W = 16;

  typedef struct packed {
    logic [PWR_W-1:0] leak;
    logic [PWR_W-1:0] dyn;
  } pwr_entry_t;
endpackage

// File: rtl/pem_activity.sv
module pem_activity #(
  parameter int NUM_STAGES = 6,
  parameter int WB_IDX     = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] rdy,
  input  logic [NUM_STAGES-1:0] hold,
  input  logic                  miss,
  output logic [NUM_STAGES-1:0] active
);
  logic miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= 1'b0;
    else        miss_q <= miss;
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    if (s == WB_IDX) begin : g_wb
      assign active[s] = (rdy[s] | hold[s]) & ~miss_q;
    end else begin : g_other
      assign active[s] = rdy[s] | hold[s];
    end
  end

  // R5: a miss forces write-back idle on the next cycle
  a_r5_wb_idle_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !active[WB_IDX]);
endmodule

// File: rtl/pem_stage_acc.sv
module pem_stage_acc import pem_pkg::*; #(
  parameter int ACC_W  = 48,
  parameter int IDX_W  = 3,
  parameter int MY_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  pwr_entry_t       cfg_entry,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] acc_nxt
);
  localparam int INC_W = PWR_W + 1;
  localparam int SUM_W = ((ACC_W > INC_W) ? ACC_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] MAXV = SUM_W'({ACC_W{1'b1}});

  pwr_entry_t       entry_q;
  logic [INC_W-1:0] inc;
  logic [SUM_W-1:0] sum_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      entry_q <= '0;
    else if (cfg_we && cfg_idx == IDX_W'(MY_IDX))
      entry_q <= cfg_entry;
  end

  always_comb begin
    inc   = INC_W'(entry_q.leak) + (active ? INC_W'(entry_q.dyn) : '0);
    sum_w = SUM_W'(acc_q) + SUM_W'(inc);
    if (clear)           acc_nxt = '0;
    else if (sum_w > MAXV) acc_nxt = '1;
    else                 acc_nxt = sum_w[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  // R7: no wrap, accumulator only grows until cleared
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> acc_q >= $past(acc_q));
  // R7: a full accumulator stays full
  a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && acc_q == {ACC_W{1'b1}}) |=> acc_q == {ACC_W{1'b1}});
endmodule

// File: rtl/pem_retire_cnt.sv
module pem_retire_cnt #(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 32,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         retire_valid,
  input  logic [TID_W-1:0]             retire_tid,
  output logic [CNT_W-1:0]             cycle_q,
  output logic [NUM_THREADS*CNT_W-1:0] thr_q,
  output logic [CNT_W-1:0]             core_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_q <= '0;
      core_q  <= '0;
    end else if (clear) begin
      cycle_q <= '0;
      core_q  <= '0;
    end else begin
      cycle_q <= cycle_q + 1'b1;
      if (retire_valid) core_q <= core_q + 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clear)  cnt <= '0;
      else if (retire_valid && retire_tid == TID_W'(t)) cnt <= cnt + 1'b1;
    end
    assign thr_q[t*CNT_W +: CNT_W] = cnt;
  end

  // R9: each retirement outside a clear steps the core count
  a_r9_core_step: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !clear) |=> core_q == $past(core_q) + 1'b1);
  // R10: cycle counter steps on every non-clear edge
  a_r10_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> cycle_q == $past(cycle_q) + 1'b1);
endmodule

// File: rtl/pem_top.sv
module pem_top import pem_pkg::*; #(
  parameter int NUM_STAGES  = 6,
  parameter int WB_IDX      = 5,
  parameter int NUM_THREADS = 4,
  parameter int ACC_W       = 48,
  parameter int CNT_W       = 32,
  localparam int IDX_W      = $clog2(NUM_STAGES + 1),
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic [NUM_STAGES-1:0]         stage_rdy,
  input  logic [NUM_STAGES-1:0]         stage_hold,
  input  logic                          dcache_miss,
  input  logic                          cfg_valid,
  output logic                          cfg_ready,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [PWR_W-1:0]              cfg_leak,
  input  logic [PWR_W-1:0]              cfg_dyn,
  input  logic                          retire_valid,
  input  logic [TID_W-1:0]              retire_tid,
  output logic [NUM_STAGES-1:0]         gate_en,
  output logic [NUM_STAGES-1:0]         stage_busy,
  output logic [NUM_STAGES*ACC_W-1:0]   stage_energy,
  output logic [ACC_W-1:0]              core_energy,
  output logic [CNT_W-1:0]              cycle_count,
  output logic [NUM_THREADS*CNT_W-1:0]  thread_retired,
  output logic [CNT_W-1:0]              core_retired
);
  localparam int TOT_W = ACC_W + $clog2(NUM_STAGES) + 1;
  localparam logic [TOT_W-1:0] TOT_MAX = TOT_W'({ACC_W{1'b1}});

  logic [NUM_STAGES-1:0] active;
  logic [ACC_W-1:0]      acc_nxt [NUM_STAGES];
  logic [TOT_W-1:0]      tot_sum;
  logic [ACC_W-1:0]      tot_q;
  pwr_entry_t            cfg_entry;

  assign cfg_ready       = 1'b1;
  assign cfg_entry.leak  = cfg_leak;
  assign cfg_entry.dyn   = cfg_dyn;
  assign gate_en         = active;
  assign stage_busy      = active;

  pem_activity #(.NUM_STAGES(NUM_STAGES), .WB_IDX(WB_IDX)) u_act (
    .clk(clk), .rst_n(rst_n), .rdy(stage_rdy), .hold(stage_hold),
    .miss(dcache_miss), .active(active)
  );

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_acc
    logic [ACC_W-1:0] acc_q;
    pem_stage_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W), .MY_IDX(s)) u_sacc (
      .clk(clk), .rst_n(rst_n), .clear(clear), .active(active[s]),
      .cfg_we(cfg_valid && cfg_ready), .cfg_idx(cfg_idx), .cfg_entry(cfg_entry),
      .acc_q(acc_q), .acc_nxt(acc_nxt[s])
    );
    assign stage_energy[s*ACC_W +: ACC_W] = acc_q;
  end

  always_comb begin
    tot_sum = '0;
    for (int s = 0; s < NUM_STAGES; s++) tot_sum = tot_sum + TOT_W'(acc_nxt[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tot_q <= '0;
    else if (tot_sum > TOT_MAX) tot_q <= '1;
    else                       tot_q <= tot_sum[ACC_W-1:0];
  end
  assign core_energy = tot_q;

  pem_retire_cnt #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .clear(clear), .retire_valid(retire_valid),
    .retire_tid(retire_tid), .cycle_q(cycle_count), .thr_q(thread_retired),
    .core_q(core_retired)
  );

  // R11: clear zeroes the core total and stage 0 on the same edge
  a_r11_clear_total: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (core_energy == '0 && stage_energy[ACC_W-1:0] == '0));
  // R8: total never falls below the fetch stage energy
  a_r8_total_covers: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> core_energy >= stage_energy[ACC_W-1:0]);
endmodule

// File: tb/sim_pem_top.sv
module sim_pem_top;
  localparam int NS = 6;
  localparam int AW = 48;
  localparam int CW = 32;
  localparam int NT = 4;
  localparam int SW = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, clear = 1'b0, dcache_miss = 1'b0;
  logic [NS-1:0] stage_rdy = '0, stage_hold = '0;
  logic cfg_valid = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [15:0] cfg_leak = '0, cfg_dyn = '0;
  logic retire_valid = 1'b0;
  logic [1:0] retire_tid = '0;

  logic cfg_ready, cfg_ready1;
  logic [NS-1:0] gate_en, stage_busy, gate_en1, busy1;
  logic [NS*AW-1:0] stage_energy;
  logic [AW-1:0] core_energy;
  logic [CW-1:0] cycle_count, core_retired, cyc1, cret1;
  logic [NT*CW-1:0] thread_retired, thr1;
  logic [NS*SW-1:0] senergy1;
  logic [SW-1:0] cenergy1;

  pem_top u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .stage_rdy(stage_rdy),
    .stage_hold(stage_hold), .dcache_miss(dcache_miss), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_idx(cfg_idx), .cfg_leak(cfg_leak), .cfg_dyn(cfg_dyn),
    .retire_valid(retire_valid), .retire_tid(retire_tid), .gate_en(gate_en),
    .stage_busy(stage_busy), .stage_energy(stage_energy), .core_energy(core_energy),
    .cycle_count(cycle_count), .thread_retired(thread_retired), .core_retired(core_retired)
  );

  pem_top #(.ACC_W(SW)) u1 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .stage_rdy(stage_rdy),
    .stage_hold(stage_hold), .dcache_miss(dcache_miss), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready1), .cfg_idx(cfg_idx), .cfg_leak(cfg_leak), .cfg_dyn(cfg_dyn),
    .retire_valid(retire_valid), .retire_tid(retire_tid), .gate_en(gate_en1),
    .stage_busy(busy1), .stage_energy(senergy1), .core_energy(cenergy1),
    .cycle_count(cyc1), .thread_retired(thr1), .core_retired(cret1)
  );

  int n_chk = 0, n_fail = 0;
  longint m_acc [NS];
  longint m_leak [NS];
  longint m_dyn [NS];
  longint m_cyc, m_core;
  longint m_thr [NT];
  logic m_mq = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_zero_counts();
    for (int s = 0; s < NS; s++) m_acc[s] = 0;
    m_cyc = 0; m_core = 0;
    for (int t = 0; t < NT; t++) m_thr[t] = 0;
  endtask

  // one clock: model follows the requirements, not the RTL
  task automatic tick();
    @(posedge clk);
    if (clear) model_zero_counts();
    else begin
      for (int s = 0; s < NS; s++) begin
        bit act = (stage_rdy[s] | stage_hold[s]) && !(s == 5 && m_mq);
        m_acc[s] += m_leak[s] + (act ? m_dyn[s] : 0);
      end
      m_cyc++;
      if (retire_valid) begin m_core++; m_thr[retire_tid]++; end
    end
    if (cfg_valid && cfg_idx < NS) begin
      m_leak[cfg_idx] = cfg_leak; m_dyn[cfg_idx] = cfg_dyn;
    end
    m_mq = dcache_miss;
    @(negedge clk);
  endtask

  task automatic check_energy(input string req);
    longint tot = 0;
    for (int s = 0; s < NS; s++) begin
      check(req, stage_energy[s*AW +: AW], m_acc[s]);
      tot += m_acc[s];
    end
    check({req, "/R8"}, core_energy, tot);
  endtask

  // {rdy[6], hold[6], miss, expected gate[6]}
  localparam logic [18:0] VEC [8] = '{
    {6'h3F, 6'h00, 1'b0, 6'h3F},
    {6'h00, 6'h00, 1'b1, 6'h00},
    {6'h3F, 6'h00, 1'b0, 6'h1F},
    {6'h00, 6'h12, 1'b0, 6'h12},
    {6'h15, 6'h0A, 1'b1, 6'h1F},
    {6'h20, 6'h00, 1'b0, 6'h00},
    {6'h00, 6'h20, 1'b0, 6'h20},
    {6'h2A, 6'h01, 1'b0, 6'h2B}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin m_leak[s] = 0; m_dyn[s] = 0; end
    model_zero_counts();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 gate", gate_en, 0);
    check("R1 core_energy", core_energy, 0);
    check("R1 cycle", cycle_count, 0);
    check("R1 retired", core_retired, 0);
    check("R6 ready", cfg_ready, 1);

    // load table: leak = s+1, dyn = 10*(s+1)
    for (int s = 0; s < NS; s++) begin
      cfg_valid = 1'b1; cfg_idx = 3'(s);
      cfg_leak = 16'(s + 1); cfg_dyn = 16'(10 * (s + 1));
      tick();
    end
    cfg_valid = 1'b0;
    check_energy("R1/R6 table load");

    // activity vectors
    for (int i = 0; i < 8; i++) begin
      stage_rdy = VEC[i][18:13]; stage_hold = VEC[i][12:7]; dcache_miss = VEC[i][6];
      #1;
      check($sformatf("R2/R3/R5 vec%0d gate", i), gate_en, VEC[i][5:0]);
      check($sformatf("R2 vec%0d busy", i), stage_busy, VEC[i][5:0]);
      tick();
    end
    stage_rdy = '0; stage_hold = '0; dcache_miss = 1'b0;
    check_energy("R4 after vectors");

    // retirements across threads
    for (int i = 0; i < 10; i++) begin
      retire_valid = (i % 3) != 2; retire_tid = 2'(i % 4);
      stage_rdy = 6'(i * 7); tick();
    end
    retire_valid = 1'b0; stage_rdy = '0;
    for (int t = 0; t < NT; t++) check("R9 thread", thread_retired[t*CW +: CW], m_thr[t]);
    check("R9 core", core_retired, m_core);
    check("R10 cycle", cycle_count, m_cyc);
    check_energy("R4 mixed");

    // long run: u1 must saturate
    stage_rdy = 6'h3F;
    repeat (1100) tick();
    stage_rdy = '0;
    check_energy("R4 long");
    for (int s = 0; s < NS; s++) check("R7 saturate", senergy1[s*SW +: SW], 1023);
    check("R7/R8 total saturate", cenergy1, 1023);

    // clear with coincident retirement
    clear = 1'b1; retire_valid = 1'b1; tick();
    clear = 1'b0; retire_valid = 1'b0;
    check("R11 core_energy", core_energy, 0);
    check("R11 retired", core_retired, 0);
    check("R11 cycle", cycle_count, 0);
    check("R11 u1", senergy1[SW-1:0], 0);

    // table write delay, stage 0 idle: old leak 1 then new leak 50
    cfg_valid = 1'b1; cfg_idx = 3'd0; cfg_leak = 16'd50; cfg_dyn = 16'd0; tick();
    cfg_valid = 1'b0;
    check("R6 old value used on write edge", stage_energy[AW-1:0], 1);
    tick();
    check("R6 new value next edge", stage_energy[AW-1:0], 51);
    check("R11 table kept", stage_energy[AW +: AW], 4);

    // out-of-range index ignored
    cfg_valid = 1'b1; cfg_idx = 3'd7; cfg_leak = 16'd999; cfg_dyn = 16'd999; tick();
    cfg_valid = 1'b0; stage_rdy = 6'h3F; tick(); tick();
    stage_rdy = '0;
    check_energy("R6 ignored index");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule